// File: doc/BRIEF.md
# Byte-to-Word Card Data FIFO Engine

This block sits between a byte-wide card data port and a small word FIFO that host software reaches through its register file. When data flows from the card to the host, incoming bytes are packed into 32-bit words, least significant byte first, and each word is pushed into the FIFO for the host to pop. When data flows from the host to the card, the host pushes words and the engine pops them and sends their bytes to the card, lowest byte first.

A transfer starts when the control register is written with the enable bit set. That write captures the direction and loads a remaining-byte counter from the programmed length. The counter drops by one for every byte that crosses the card port. When it reaches zero, the done flags rise. Once the counter is zero and the FIFO has drained, the enable bit clears itself. The engine also produces FIFO level flags for the active direction only, along with a word-count readback derived from the remaining bytes.

Top module: `card_word_fifo`

## Requirements
- R1: After reset, xfer_en, bytes_left, words_left, data_end, block_end, rx_flags, tx_flags, crx_ready, ctx_valid and host_rdata are all 0.
- R2: A ctrl_wr pulse with ctrl_en=1 sets xfer_en, captures ctrl_dir into xfer_dir (1 = card to host, 0 = host to card), loads bytes_left from len_i and clears data_end and block_end. These take effect at the following clock edge.
- R3: Card to host: accepted bytes fill a word from bit 7:0 upward. The word enters the FIFO after its 4th byte, or after the transfer's last byte with the unfilled upper bytes zero. The host pops words in the order they were filled.
- R4: crx_ready is 1 exactly when xfer_en=1, xfer_dir=1, bytes_left>0 and the FIFO holds fewer than 16 words.
- R5: Host to card: ctx_valid is 1 exactly when xfer_en=1, xfer_dir=0, bytes_left>0, and either the FIFO is non-empty or a popped word still has unsent bytes. Each popped word is sent bits 7:0 first, then 15:8, 23:16 and 31:24.
- R6: bytes_left decreases by exactly one on each card-side byte handshake.
- R7: data_end and block_end become 1 one cycle after bytes_left is 0 with xfer_en=1. They stay 1 until the next enabling ctrl_wr.
- R8: When bytes_left is 0 and the FIFO is empty, rx_flags and tx_flags read 0 and xfer_en clears at the next edge.
- R9: During an active transfer, the flag group uses these bits: bit 0 active = 1; bit 1 = fill>=8 for the RX group or fill<=8 for the TX group; bit 2 full = fill==16; bit 3 empty = fill==0; bit 4 available = fill>0.
- R10: Only rx_flags can be non-zero when xfer_dir=1, and only tx_flags when xfer_dir=0.
- R11: words_left always equals (bytes_left + 3) >> 2.
- R12: A host push is taken only when xfer_en=1, xfer_dir=0, bytes_left>0 and the FIFO is not full; any other push is ignored. A host pop is taken only when xfer_dir=1 and the FIFO is not empty; otherwise host_rdata is 0 and the FIFO is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Enable bit value written with ctrl_wr |
| ctrl_dir | input | 1 | Direction value written with ctrl_wr (1 = card to host) |
| len_i | input | LEN_W | Programmed transfer length in bytes |
| host_push | input | 1 | Host FIFO write strobe |
| host_wdata | input | 32 | Host FIFO write word |
| host_pop | input | 1 | Host FIFO read strobe |
| host_rdata | output | 32 | FIFO head word offered to the host, 0 when no pop is possible |
| crx_valid | input | 1 | Card offers a byte |
| crx_data | input | 8 | Byte from the card |
| crx_ready | output | 1 | Engine accepts a card byte this cycle |
| ctx_valid | output | 1 | Engine offers a byte to the card |
| ctx_data | output | 8 | Byte to the card |
| ctx_ready | input | 1 | Card takes the offered byte |
| xfer_en | output | 1 | Enable bit of the data control register |
| xfer_dir | output | 1 | Captured direction |
| bytes_left | output | LEN_W | Remaining byte count |
| words_left | output | LEN_W-1 | Remaining count in words, rounded up |
| data_end | output | 1 | Transfer byte count exhausted |
| block_end | output | 1 | Block finished, raised together with data_end |
| rx_flags | output | 5 | Card-to-host FIFO flag group |
| tx_flags | output | 5 | Host-to-card FIFO flag group |

## Verification
A wrong fill count or pointer shows at the ports within a cycle, as a wrong flag pattern or ready level. A wrong pointer also shows as a wrong byte or word at the next pop. A packing or unpacking error surfaces as a mismatched byte lane on the first word of any transfer whose length exercises that lane. That is why every length from 0 to 12 is swept, plus lengths that fill the FIFO to 16 entries. A counter that slips shows immediately in bytes_left and words_left. A missed self-clear or done flag shows within two cycles of the last byte or pop.

// File: rtl/card_word_fifo_pkg.sv
package card_word_fifo_pkg;

  // bit positions inside each flag group
  localparam int FL_ACTIVE = 0;
  localparam int FL_HALF   = 1;
  localparam int FL_FULL   = 2;
  localparam int FL_EMPTY  = 3;
  localparam int FL_AVAIL  = 4;
  localparam int FL_W      = 5;

  // merge a new byte into a partly gathered word at byte slot 'slot'
  function automatic logic [31:0] put_byte(input logic [23:0] acc,
                                           input logic [1:0]  slot,
                                           input logic [7:0]  b);
    logic [31:0] w;
    w = {8'h00, acc};
    w[{slot, 3'b000} +: 8] = b;
    return w;
  endfunction

  // level flags for one direction; rx_side picks the half-level sense
  function automatic logic [FL_W-1:0] group_flags(input logic [31:0] fill,
                                                  input logic [31:0] depth,
                                                  input logic rx_side);
    logic [FL_W-1:0] f;
    f            = '0;
    f[FL_ACTIVE] = 1'b1;
    f[FL_HALF]   = rx_side ? (fill * 2 >= depth) : (fill * 2 <= depth);
    f[FL_FULL]   = (fill == depth);
    f[FL_EMPTY]  = (fill == 0);
    f[FL_AVAIL]  = (fill != 0);
    return f;
  endfunction

endpackage

// File: rtl/word_ring.sv
module word_ring #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     fill
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q;
  logic [AW:0]   fill_q;
  logic [AW-1:0] wr_idx;
  logic          do_push, do_pop;

  // write slot sits fill entries past the read pointer, wrapping
  assign wr_idx  = rd_q + fill_q[AW-1:0];
  assign do_push = push && (fill_q != (AW+1)'(DEPTH));
  assign do_pop  = pop && (fill_q != '0);
  assign head    = mem[rd_q];
  assign fill    = fill_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (do_pop) rd_q <= rd_q + 1'b1;
      if (do_push && !do_pop)      fill_q <= fill_q + 1'b1;
      else if (do_pop && !do_push) fill_q <= fill_q - 1'b1;
    end
  end
endmodule

// File: rtl/rx_packer.sv
module rx_packer
  import card_word_fifo_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic [7:0]  in_byte,
  input  logic        last,
  output logic        word_done,
  output logic [31:0] word
);
  logic [23:0] acc_q;
  logic [1:0]  slot_q;

  assign word      = put_byte(acc_q, slot_q, in_byte);
  assign word_done = take && (slot_q == 2'd3 || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      slot_q <= '0;
    end else if (clear) begin
      acc_q  <= '0;
      slot_q <= '0;
    end else if (take) begin
      if (word_done) begin
        acc_q  <= '0;
        slot_q <= '0;
      end else begin
        acc_q  <= word[23:0];
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tx_unpacker.sv
module tx_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic [31:0] head,
  output logic        part,
  output logic [7:0]  cur_byte
);
  logic [23:0] rest_q;
  logic [1:0]  left_q;

  assign part     = (left_q != 2'd0);
  assign cur_byte = part ? rest_q[7:0] : head[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rest_q <= '0;
      left_q <= '0;
    end else if (clear) begin
      rest_q <= '0;
      left_q <= '0;
    end else if (take) begin
      if (part) begin
        rest_q <= {8'h00, rest_q[23:8]};
        left_q <= left_q - 1'b1;
      end else begin
        rest_q <= head[31:8];
        left_q <= 2'd3;
      end
    end
  end
endmodule

// File: rtl/card_word_fifo.sv
module card_word_fifo
  import card_word_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             ctrl_en,
  input  logic             ctrl_dir,
  input  logic [LEN_W-1:0] len_i,
  input  logic             host_push,
  input  logic [31:0]      host_wdata,
  input  logic             host_pop,
  output logic [31:0]      host_rdata,
  input  logic             crx_valid,
  input  logic [7:0]       crx_data,
  output logic             crx_ready,
  output logic             ctx_valid,
  output logic [7:0]       ctx_data,
  input  logic             ctx_ready,
  output logic             xfer_en,
  output logic             xfer_dir,
  output logic [LEN_W-1:0] bytes_left,
  output logic [LEN_W-2:0] words_left,
  output logic             data_end,
  output logic             block_end,
  output logic [FL_W-1:0]  rx_flags,
  output logic [FL_W-1:0]  tx_flags
);
  localparam int FW = $clog2(DEPTH) + 1;

  logic             en_q, dir_q, done_q;
  logic [LEN_W-1:0] rem_q;
  logic [FW-1:0]    fill_w;
  logic [31:0]      head_w;
  logic [LEN_W:0]   wl_sum;

  // named internal events
  logic rem_zero, fifo_full, fifo_empty, idle_w, busy_w;
  logic rx_hs, tx_hs, card_pop, host_push_ok, host_pop_ok;
  logic pk_done, upk_part, start_w, byte_moved;
  logic fifo_push, fifo_pop;
  logic [31:0] pk_word, fifo_wdata;
  logic [7:0]  upk_byte;
  logic [FL_W-1:0] grp_w;

  assign rem_zero   = (rem_q == '0);
  assign fifo_full  = (fill_w == FW'(DEPTH));
  assign fifo_empty = (fill_w == '0);
  assign idle_w     = rem_zero && fifo_empty;
  assign busy_w     = en_q && !idle_w;
  assign start_w    = ctrl_wr && ctrl_en;

  // card side
  assign crx_ready  = en_q && dir_q && !rem_zero && !fifo_full;
  assign rx_hs      = crx_valid && crx_ready;
  assign ctx_valid  = en_q && !dir_q && !rem_zero && (upk_part || !fifo_empty);
  assign tx_hs      = ctx_valid && ctx_ready;
  assign ctx_data   = upk_byte;
  assign card_pop   = tx_hs && !upk_part;
  assign byte_moved = rx_hs || tx_hs;

  // host side
  assign host_push_ok = host_push && en_q && !dir_q && !rem_zero && !fifo_full;
  assign host_pop_ok  = host_pop && dir_q && !fifo_empty;
  assign host_rdata   = (dir_q && !fifo_empty) ? head_w : 32'h0;

  assign fifo_push  = dir_q ? pk_done : host_push_ok;
  assign fifo_wdata = dir_q ? pk_word : host_wdata;
  assign fifo_pop   = dir_q ? host_pop_ok : card_pop;

  word_ring #(.DEPTH(DEPTH), .W(32)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .push(fifo_push), .push_data(fifo_wdata),
    .pop(fifo_pop), .head(head_w), .fill(fill_w)
  );

  rx_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clear(start_w),
    .take(rx_hs), .in_byte(crx_data), .last(rem_q == LEN_W'(1)),
    .word_done(pk_done), .word(pk_word)
  );

  tx_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .clear(start_w),
    .take(tx_hs), .head(head_w),
    .part(upk_part), .cur_byte(upk_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
    end else if (ctrl_wr) begin
      en_q  <= ctrl_en;
      dir_q <= ctrl_dir;
      if (ctrl_en) begin
        rem_q  <= len_i;
        done_q <= 1'b0;
      end
    end else begin
      if (byte_moved)          rem_q  <= rem_q - 1'b1;
      if (en_q && rem_zero)    done_q <= 1'b1;
      if (en_q && idle_w)      en_q   <= 1'b0;
    end
  end

  // status outputs
  assign wl_sum     = {1'b0, rem_q} + (LEN_W+1)'(3);
  assign words_left = wl_sum[LEN_W:2];
  assign bytes_left = rem_q;
  assign xfer_en    = en_q;
  assign xfer_dir   = dir_q;
  assign data_end   = done_q;
  assign block_end  = done_q;
  assign grp_w      = group_flags(32'(fill_w), 32'(DEPTH), dir_q);
  assign rx_flags   = (busy_w && dir_q)  ? grp_w : '0;
  assign tx_flags   = (busy_w && !dir_q) ? grp_w : '0;

endmodule

// File: rtl/card_word_fifo_chk.sv
module card_word_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic [LEN_W-1:0]       rem,
  input logic [$clog2(DEPTH):0] fill,
  input logic                   rx_hs,
  input logic                   tx_hs,
  input logic                   ctrl_wr,
  input logic                   crx_ready,
  input logic [4:0]             rx_flags,
  input logic [4:0]             tx_flags,
  input logic                   data_end,
  input logic                   fifo_pop
);
  localparam int FW = $clog2(DEPTH) + 1;

  p_fill_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  p_full_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(DEPTH) && !fifo_pop) |=> (fill == FW'(DEPTH)));

  p_ready_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == FW'(DEPTH)) |-> !crx_ready);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_hs || tx_hs) && !ctrl_wr) |=> (rem == LEN_W'($past(rem) - 1'b1)));

  p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rem == '0 && fill == '0 && !ctrl_wr) |=> !en);

  p_idle_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rx_flags == '0 && tx_flags == '0));

  p_dir_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !((rx_flags != '0) && (tx_flags != '0)));

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rem == '0 && !ctrl_wr) |=> data_end);

endmodule

bind card_word_fifo card_word_fifo_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .rem(rem_q), .fill(fill_w),
  .rx_hs(rx_hs), .tx_hs(tx_hs), .ctrl_wr(ctrl_wr), .crx_ready(crx_ready),
  .rx_flags(rx_flags), .tx_flags(tx_flags), .data_end(data_end),
  .fifo_pop(fifo_pop)
);

// File: tb/sim_card_word_fifo.sv
`timescale 1ns/1ps
module sim_card_word_fifo;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 0, ctrl_en = 0, ctrl_dir = 0;
  logic [LEN_W-1:0] len_i = '0;
  logic host_push = 0, host_pop = 0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic crx_valid = 0, crx_ready;
  logic [7:0] crx_data = '0, ctx_data;
  logic ctx_valid, ctx_ready = 0;
  logic xfer_en, xfer_dir, data_end, block_end;
  logic [LEN_W-1:0] bytes_left;
  logic [LEN_W-2:0] words_left;
  logic [4:0] rx_flags, tx_flags;

  int n_chk = 0, n_err = 0;

  card_word_fifo #(.DEPTH(16), .LEN_W(LEN_W)) u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flag group as the requirement lists it: active, half, full, empty, available
  function automatic logic [4:0] model_flags(int f, bit rx);
    logic [4:0] r;
    r[0] = 1'b1;
    r[1] = rx ? (f >= 8) : (f <= 8);
    r[2] = (f == 16);
    r[3] = (f == 0);
    r[4] = (f > 0);
    return r;
  endfunction

  function automatic logic [7:0] rx_byte(int L, int i);
    return 8'((L * 29 + i * 71 + 5) % 256);
  endfunction

  function automatic logic [31:0] rx_word(int L, int w);
    logic [31:0] v = 0;
    for (int k = 0; k < 4; k++)
      if (4 * w + k < L) v = v + (32'(rx_byte(L, 4 * w + k)) << (8 * k));
    return v;
  endfunction

  function automatic logic [31:0] tx_word(int L, int j);
    return 32'(j) * 32'h01030507 + 32'(L) * 32'h00000011 + 32'h80402010;
  endfunction

  task automatic start(bit dir, int L);
    @(negedge clk);
    ctrl_wr = 1; ctrl_en = 1; ctrl_dir = dir; len_i = LEN_W'(L);
    @(negedge clk);
    ctrl_wr = 0; ctrl_en = 0;
    chk("R2 xfer_en", 32'(xfer_en), 1);
    chk("R2 xfer_dir", 32'(xfer_dir), 32'(dir));
    chk("R2 bytes_left load", 32'(bytes_left), 32'(L));
    chk("R2 data_end cleared", 32'(data_end), 0);
  endtask

  task automatic finish_check(string tag);
    chk({tag, " R8 rx_flags idle"}, 32'(rx_flags), 0);
    chk({tag, " R8 tx_flags idle"}, 32'(tx_flags), 0);
    @(negedge clk);
    chk({tag, " R8 enable self-clear"}, 32'(xfer_en), 0);
    chk({tag, " R7 data_end"}, 32'(data_end), 1);
    chk({tag, " R7 block_end"}, 32'(block_end), 1);
  endtask

  task automatic run_rx(int L, bit try_push);
    int acc = 0, popped = 0, mfill = 0, cyc = 0;
    int nw = (L + 3) / 4;
    start(1'b1, L);
    while (popped < nw && cyc < 3000) begin
      int mrem = L - acc;
      bit rdy = (mrem > 0) && (mfill < 16);
      chk("R6 rx bytes_left", 32'(bytes_left), 32'(mrem));
      chk("R11 rx words_left", 32'(words_left), 32'((mrem + 3) >> 2));
      chk("R9 rx_flags", 32'(rx_flags),
          (mrem == 0 && mfill == 0) ? 0 : 32'(model_flags(mfill, 1)));
      chk("R10 tx_flags masked", 32'(tx_flags), 0);
      chk("R4 crx_ready", 32'(crx_ready), 32'(rdy));
      crx_valid = 0; host_pop = 0; host_push = 0;
      if (try_push && cyc == 0) begin
        host_push = 1; host_wdata = 32'hBAD0BAD0;   // R12 ignored in read direction
      end
      if (rdy) begin
        crx_valid = 1; crx_data = rx_byte(L, acc);
        acc++;
        if (acc % 4 == 0 || acc == L) mfill++;
      end else if (mfill > 0) begin
        chk("R3 rx packed word", host_rdata, rx_word(L, popped));
        host_pop = 1;
        popped++; mfill--;
      end
      @(negedge clk);
      cyc++;
    end
    crx_valid = 0; host_pop = 0; host_push = 0;
    chk("R6 rx bytes_left end", 32'(bytes_left), 0);
    finish_check("rx");
  endtask

  task automatic run_tx(int L, bit fill_first);
    int pushed = 0, sent = 0, mfill = 0, cyc = 0;
    int nw = (L + 3) / 4;
    start(1'b0, L);
    if (fill_first) begin
      ctx_ready = 0;
      while (pushed < nw && mfill < 16) begin
        host_push = 1; host_wdata = tx_word(L, pushed);
        pushed++; mfill++;
        @(negedge clk);
      end
      host_push = 0;
      chk("R9 tx full flags", 32'(tx_flags), 32'(model_flags(16, 0)));
      host_push = 1; host_wdata = 32'hDEADBEEF;     // R12 push to full ignored
      @(negedge clk);
      host_push = 0;
      chk("R12 full after extra push", 32'(tx_flags), 32'(model_flags(16, 0)));
    end
    while (sent < L && cyc < 5000) begin
      int mrem = L - sent;
      bit vld = (mfill > 0) || (sent % 4 != 0);
      bit rdy = (cyc % 3 != 1);
      int f0 = mfill;
      chk("R6 tx bytes_left", 32'(bytes_left), 32'(mrem));
      chk("R11 tx words_left", 32'(words_left), 32'((mrem + 3) >> 2));
      chk("R9 tx_flags", 32'(tx_flags), 32'(model_flags(mfill, 0)));
      chk("R10 rx_flags masked", 32'(rx_flags), 0);
      chk("R5 ctx_valid", 32'(ctx_valid), 32'(vld));
      chk("R12 host_rdata in write dir", host_rdata, 0);
      if (vld)
        chk("R5 tx byte order", 32'(ctx_data),
            32'(8'(tx_word(L, sent / 4) >> (8 * (sent % 4)))));
      ctx_ready = rdy; host_push = 0;
      host_pop = (cyc % 5 == 2);
      if (vld && rdy) begin
        if (sent % 4 == 0) mfill--;
        sent++;
      end
      if (pushed < nw && f0 < 16) begin
        host_push = 1; host_wdata = tx_word(L, pushed);
        pushed++; mfill++;
      end
      @(negedge clk);
      cyc++;
    end
    ctx_ready = 0; host_push = 0; host_pop = 0;
    chk("R6 tx bytes_left end", 32'(bytes_left), 0);
    finish_check("tx");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 xfer_en", 32'(xfer_en), 0);
    chk("R1 bytes_left", 32'(bytes_left), 0);
    chk("R1 words_left", 32'(words_left), 0);
    chk("R1 data_end", 32'(data_end), 0);
    chk("R1 block_end", 32'(block_end), 0);
    chk("R1 flags", 32'({rx_flags, tx_flags}), 0);
    chk("R1 handshakes", 32'({crx_ready, ctx_valid}), 0);
    chk("R1 host_rdata", host_rdata, 0);
    rst_n = 1;
    @(negedge clk);

    for (int L = 0; L <= 12; L++) run_rx(L, L == 5);
    run_rx(64, 1'b0);
    run_rx(80, 1'b1);

    // R12 pop from empty FIFO in read direction
    host_pop = 1;
    chk("R12 empty pop data", host_rdata, 0);
    @(negedge clk);
    host_pop = 0;
    run_rx(7, 1'b0);

    for (int L = 1; L <= 12; L++) run_tx(L, 1'b0);
    run_tx(70, 1'b1);
    run_tx(64, 1'b1);
    run_tx(0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule